// File: doc/BRIEF.md
# Simple Target Bus Protocol Monitor

This block watches one segment of a single-initiator, multi-target synchronous bus. In one cycle of that bus the initiator holds a request and the addressed target answers with an acknowledge. The monitor is passive and drives nothing on the bus. On every rising clock edge it samples the request, acknowledge, command, address, byte enables and write data. It checks the ordering rules that both sides must obey. Each rule has its own sticky error bit, and a single combined error output reflects all of them.

The monitor also keeps a warning flag for requests that carry no active byte. It counts completed read cycles and completed write cycles. It is intended for simulation and for on-chip debug builds. Its flags can be cleared at any time by a one-cycle synchronous clear pulse, so a test or a debug session can check a protocol window in isolation. The data width is a parameter from 8 to 64 bits, and the byte-enable width follows from it.

Top module: `stbus_monitor`

## Requirements
- R1: A cycle completes on a rising edge where request and acknowledge are both high. When the command has bit 2 set (codes 1xx, which include the program-memory read codes 11x), `rd_count` is one higher after that edge.
- R2: A completed cycle whose command has bit 2 clear (codes 0xx, either the waited write with bit 1 clear or the posted write with bit 1 set) makes `wr_count` one higher after that edge. It leaves `rd_count` unchanged.
- R3: Suppose the request was high at the previous edge and that edge did not complete a cycle. Then any change in address, byte enables or command at the current edge sets `err_flags[0]`. A change after a completed cycle sets no flag.
- R4: With the same pending condition and a write command at the previous edge, a change of write data sets `err_flags[1]`. A change of write data under a pending read sets nothing.
- R5: A request that falls without a completed cycle at the previous edge sets `err_flags[2]`. A fall that follows a completed cycle is legal.
- R6: An acknowledge that falls without a completed cycle at the previous edge sets `err_flags[3]`. A fall that follows a completed cycle is legal.
- R7: On buses wider than 8 bits, a request with every active-low byte-enable bit high sets `warn_no_bytes`. This condition does not set any error bit.
- R8: Error bits and the warning stay set until `err_clr` is sampled high. A violation detected at the same edge as the clear is still recorded. `err_any` is high whenever any error bit is set.
- R9: While `rst_n` is low, all flags and both counters are zero. Each flag is set one edge after the violation is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| err_clr | input | 1 | Synchronous clear of error and warning flags |
| mon_req | input | 1 | Observed cycle request |
| mon_ack | input | 1 | Observed cycle acknowledge |
| mon_cmd | input | 3 | Observed command code |
| mon_addr | input | AW | Observed word address |
| mon_nbe | input | DW/8 | Observed byte enables, active low |
| mon_wdata | input | DW | Observed write data |
| err_flags | output | 4 | Sticky per-rule error bits |
| err_any | output | 1 | OR of all error bits |
| warn_no_bytes | output | 1 | Sticky empty-byte-enable warning |
| rd_count | output | CNT_W | Completed read cycles, wrapping |
| wr_count | output | CNT_W | Completed write cycles, wrapping |

## Verification
The monitor's only memory is the previous-edge snapshot, the flags and the counters, so any corruption shows up at the ports within one edge. A stale snapshot of the handshake shows up as a false flag or a missed flag on the edge after a legal or illegal fall. A bad snapshot of the fields shows up on the first pending cycle as a wrong `err_flags[0]` or `err_flags[1]`. A decode error in the command shows up as the wrong counter moving on the edge that completes the cycle. Directed sequences pair every illegal transition with its legal twin, so a flag that is raised too eagerly is caught as well as one that is missing.

// File: rtl/stm_pkg.sv
// Shared constants and command decode helpers for the bus monitor.
// Assumes command bit 2 separates reads (1) from writes (0).
package stm_pkg;
    localparam int NUM_RULES = 4;
    localparam int ERR_CTRL  = 0;  // address/byte-enable/command held
    localparam int ERR_WDATA = 1;  // write data held
    localparam int ERR_REQ   = 2;  // request fell early
    localparam int ERR_ACK   = 3;  // acknowledge fell early

    function automatic logic cmd_is_read(input logic [2:0] cmd);
        return cmd[2];
    endfunction

    function automatic logic cmd_is_write(input logic [2:0] cmd);
        return ~cmd[2];
    endfunction
endpackage

// File: rtl/stm_sample.sv
// Previous-edge snapshot of the observed bus.
// Assumes reset values model an idle bus, so no rule can fire on the first edge.
module stm_sample #(
    parameter int AW  = 16,
    parameter int DW  = 32,
    parameter int NBW = DW / 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cur_req,
    input  logic           cur_ack,
    input  logic [2:0]     cur_cmd,
    input  logic [AW-1:0]  cur_addr,
    input  logic [NBW-1:0] cur_nbe,
    input  logic [DW-1:0]  cur_wdata,
    output logic           p_req,
    output logic           p_ack,
    output logic           p_hs,
    output logic [2:0]     p_cmd,
    output logic [AW-1:0]  p_addr,
    output logic [NBW-1:0] p_nbe,
    output logic [DW-1:0]  p_wdata
);
    // Capture every bus field once per edge for next-edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_req   <= 1'b0;
            p_ack   <= 1'b0;
            p_hs    <= 1'b0;
            p_cmd   <= '0;
            p_addr  <= '0;
            p_nbe   <= '1;
            p_wdata <= '0;
        end else begin
            p_req   <= cur_req;
            p_ack   <= cur_ack;
            p_hs    <= cur_req & cur_ack;
            p_cmd   <= cur_cmd;
            p_addr  <= cur_addr;
            p_nbe   <= cur_nbe;
            p_wdata <= cur_wdata;
        end
    end
endmodule

// File: rtl/stm_rules.sv
// Combinational rule evaluation: compares current bus values with the snapshot.
// Assumes the snapshot comes from stm_sample one edge earlier.
module stm_rules
    import stm_pkg::*;
#(
    parameter int AW  = 16,
    parameter int DW  = 32,
    parameter int NBW = DW / 8
) (
    input  logic                 cur_req,
    input  logic                 cur_ack,
    input  logic [2:0]           cur_cmd,
    input  logic [AW-1:0]        cur_addr,
    input  logic [NBW-1:0]       cur_nbe,
    input  logic [DW-1:0]        cur_wdata,
    input  logic                 p_req,
    input  logic                 p_ack,
    input  logic                 p_hs,
    input  logic [2:0]           p_cmd,
    input  logic [AW-1:0]        p_addr,
    input  logic [NBW-1:0]       p_nbe,
    input  logic [DW-1:0]        p_wdata,
    output logic [NUM_RULES-1:0] viol,
    output logic                 warn_hit
);
    logic pending;

    // Flag each ordering rule broken at this edge.
    always_comb begin
        pending          = p_req & ~p_hs;
        viol             = '0;
        viol[ERR_CTRL]   = pending & ((cur_addr != p_addr) |
                                      (cur_nbe  != p_nbe)  |
                                      (cur_cmd  != p_cmd));
        viol[ERR_WDATA]  = pending & cmd_is_write(p_cmd) & (cur_wdata != p_wdata);
        viol[ERR_REQ]    = pending & ~cur_req;
        viol[ERR_ACK]    = p_ack & ~p_hs & ~cur_ack;
    end

    // Empty byte-enable check exists only when byte enables carry meaning.
    generate
        if (NBW > 1) begin : g_warn
            assign warn_hit = cur_req & (&cur_nbe);
        end else begin : g_nowarn
            assign warn_hit = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/stm_sticky.sv
// Bank of sticky flags with synchronous clear; a set in the clear cycle wins.
module stm_sticky #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic [N-1:0] set,
    output logic [N-1:0] q
);
    // Accumulate new hits, restart from this edge's hits on clear.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (clr) q <= set;
        else          q <= q | set;
    end
endmodule

// File: rtl/stm_counter.sv
// Wrapping event counter.
module stm_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    // Advance by one on each qualifying event.
    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (inc) count <= count + 1'b1;
    end
endmodule

// File: rtl/stbus_monitor.sv
// Passive protocol monitor for one simple target bus segment.
// Assumes all inputs are synchronous to clk; drives nothing on the bus.
module stbus_monitor
    import stm_pkg::*;
#(
    parameter int AW    = 16,
    parameter int DW    = 32,
    parameter int CNT_W = 16,
    localparam int NBW  = DW / 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 err_clr,
    input  logic                 mon_req,
    input  logic                 mon_ack,
    input  logic [2:0]           mon_cmd,
    input  logic [AW-1:0]        mon_addr,
    input  logic [NBW-1:0]       mon_nbe,
    input  logic [DW-1:0]        mon_wdata,
    output logic [NUM_RULES-1:0] err_flags,
    output logic                 err_any,
    output logic                 warn_no_bytes,
    output logic [CNT_W-1:0]     rd_count,
    output logic [CNT_W-1:0]     wr_count
);
    logic           p_req, p_ack, p_hs;
    logic [2:0]     p_cmd;
    logic [AW-1:0]  p_addr;
    logic [NBW-1:0] p_nbe;
    logic [DW-1:0]  p_wdata;
    logic [NUM_RULES-1:0] viol;
    logic           warn_hit;
    logic [NUM_RULES:0]   flag_q;
    logic           hs_now;
    logic [1:0]     cnt_inc;
    logic [CNT_W-1:0] cnt_val [2];

    stm_sample #(.AW(AW), .DW(DW), .NBW(NBW)) u_sample (
        .clk(clk), .rst_n(rst_n),
        .cur_req(mon_req), .cur_ack(mon_ack), .cur_cmd(mon_cmd),
        .cur_addr(mon_addr), .cur_nbe(mon_nbe), .cur_wdata(mon_wdata),
        .p_req(p_req), .p_ack(p_ack), .p_hs(p_hs), .p_cmd(p_cmd),
        .p_addr(p_addr), .p_nbe(p_nbe), .p_wdata(p_wdata)
    );

    stm_rules #(.AW(AW), .DW(DW), .NBW(NBW)) u_rules (
        .cur_req(mon_req), .cur_ack(mon_ack), .cur_cmd(mon_cmd),
        .cur_addr(mon_addr), .cur_nbe(mon_nbe), .cur_wdata(mon_wdata),
        .p_req(p_req), .p_ack(p_ack), .p_hs(p_hs), .p_cmd(p_cmd),
        .p_addr(p_addr), .p_nbe(p_nbe), .p_wdata(p_wdata),
        .viol(viol), .warn_hit(warn_hit)
    );

    // Warning rides in the top bit of the same sticky bank as the errors.
    stm_sticky #(.N(NUM_RULES + 1)) u_flags (
        .clk(clk), .rst_n(rst_n), .clr(err_clr),
        .set({warn_hit, viol}), .q(flag_q)
    );

    // Decode completed cycles into read and write events.
    always_comb begin
        hs_now     = mon_req & mon_ack;
        cnt_inc[0] = hs_now & cmd_is_read(mon_cmd);
        cnt_inc[1] = hs_now & cmd_is_write(mon_cmd);
    end

    generate
        for (genvar g = 0; g < 2; g++) begin : g_cnt
            stm_counter #(.W(CNT_W)) u_cnt (
                .clk(clk), .rst_n(rst_n), .inc(cnt_inc[g]), .count(cnt_val[g])
            );
        end
    endgenerate

    assign err_flags     = flag_q[NUM_RULES-1:0];
    assign warn_no_bytes = flag_q[NUM_RULES];
    assign err_any       = |flag_q[NUM_RULES-1:0];
    assign rd_count      = cnt_val[0];
    assign wr_count      = cnt_val[1];
endmodule

// File: rtl/stm_monitor_chk.sv
// Property checker bound to stbus_monitor; relates its ports across edges.
module stm_monitor_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             err_clr,
    input logic             mon_req,
    input logic             mon_ack,
    input logic [2:0]       mon_cmd,
    input logic [3:0]       err_flags,
    input logic [CNT_W-1:0] rd_count,
    input logic [CNT_W-1:0] wr_count
);
    AST_RD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(mon_req && mon_ack && mon_cmd[2])
        |-> rd_count == CNT_W'($past(rd_count) + 1'b1)); // R1
    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(mon_req && mon_ack && mon_cmd[2])
        |-> rd_count == $past(rd_count)); // R1
    AST_WR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && $past(mon_req && mon_ack && !mon_cmd[2])
        |-> wr_count == CNT_W'($past(wr_count) + 1'b1)); // R2
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(mon_req && mon_ack && !mon_cmd[2])
        |-> wr_count == $past(wr_count)); // R2
    AST_REQ_EARLY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mon_req && !mon_ack) && !mon_req |=> err_flags[2]); // R5
    AST_ACK_EARLY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mon_ack && !mon_req) && !mon_ack |=> err_flags[3]); // R6
    AST_FLAGS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) && !$past(err_clr)
        |-> (err_flags & $past(err_flags)) == $past(err_flags)); // R8
endmodule

bind stbus_monitor stm_monitor_chk #(.CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .err_clr(err_clr),
    .mon_req(mon_req), .mon_ack(mon_ack), .mon_cmd(mon_cmd),
    .err_flags(err_flags), .rd_count(rd_count), .wr_count(wr_count)
);

// File: tb/sim_stbus_monitor.sv
module sim_stbus_monitor;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        err_clr = 1'b0;
    logic        mon_req = 1'b0;
    logic        mon_ack = 1'b0;
    logic [2:0]  mon_cmd = '0;
    logic [15:0] mon_addr = '0;
    logic [3:0]  mon_nbe = '0;
    logic [31:0] mon_wdata = '0;
    logic [3:0]  err_flags;
    logic        err_any, warn_no_bytes;
    logic [15:0] rd_count, wr_count;

    int checks = 0;
    int fails  = 0;
    int exp_rd = 0;
    int exp_wr = 0;

    stbus_monitor u0 (
        .clk(clk), .rst_n(rst_n), .err_clr(err_clr),
        .mon_req(mon_req), .mon_ack(mon_ack), .mon_cmd(mon_cmd),
        .mon_addr(mon_addr), .mon_nbe(mon_nbe), .mon_wdata(mon_wdata),
        .err_flags(err_flags), .err_any(err_any), .warn_no_bytes(warn_no_bytes),
        .rd_count(rd_count), .wr_count(wr_count)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Apply one bus beat, let one edge pass, return 2 ns after it.
    task automatic beat(input logic rq, input logic ak, input logic [2:0] cm,
                        input logic [15:0] ad, input logic [3:0] nb, input logic [31:0] wd);
        mon_req = rq; mon_ack = ak; mon_cmd = cm;
        mon_addr = ad; mon_nbe = nb; mon_wdata = wd;
        @(posedge clk); #2;
    endtask

    task automatic idle();
        beat(1'b0, 1'b0, 3'b000, 16'h0, 4'h0, 32'h0);
    endtask

    task automatic clear_flags();
        err_clr = 1'b1; idle(); err_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R9 flags in reset", {28'h0, err_flags}, 32'h0);
        chk("R9 rd_count in reset", {16'h0, rd_count}, 32'h0);
        chk("R9 wr_count in reset", {16'h0, wr_count}, 32'h0);
        chk("R9 warn in reset", {31'h0, warn_no_bytes}, 32'h0);
    endtask

    task automatic t_reads();
        beat(1, 0, 3'b100, 16'h0010, 4'h0, 32'h0);
        beat(1, 1, 3'b100, 16'h0010, 4'h0, 32'h0); exp_rd++;
        chk("R1 io read counted", {16'h0, rd_count}, exp_rd);
        beat(1, 1, 3'b110, 16'h0020, 4'h0, 32'h0); exp_rd++;
        chk("R1 program read counted", {16'h0, rd_count}, exp_rd);
        beat(1, 1, 3'b111, 16'h0021, 4'h0, 32'h0); exp_rd++;
        idle();
        chk("R1 reads total", {16'h0, rd_count}, exp_rd);
        chk("R5 R6 legal falls after handshake", {28'h0, err_flags}, 32'h0);
    endtask

    task automatic t_writes();
        beat(1, 1, 3'b000, 16'h0030, 4'h0, 32'hAAAA0001); exp_wr++;
        chk("R2 waited write counted", {16'h0, wr_count}, exp_wr);
        beat(1, 1, 3'b011, 16'h0031, 4'h0, 32'hAAAA0002); exp_wr++;
        beat(1, 1, 3'b010, 16'h0032, 4'h0, 32'hAAAA0003); exp_wr++;
        idle();
        chk("R2 posted writes counted", {16'h0, wr_count}, exp_wr);
        chk("R2 reads untouched", {16'h0, rd_count}, exp_rd);
        chk("R3 changes after handshake legal", {28'h0, err_flags}, 32'h0);
    endtask

    task automatic t_hold_ctrl();
        beat(1, 0, 3'b101, 16'h0040, 4'h0, 32'h0);
        chk("R3 no flag while held", {28'h0, err_flags}, 32'h0);
        beat(1, 0, 3'b101, 16'h0041, 4'h0, 32'h0);
        chk("R3 address change flagged", {28'h0, err_flags}, 32'h1);
        chk("R8 err_any follows", {31'h0, err_any}, 32'h1);
        beat(1, 1, 3'b101, 16'h0041, 4'h0, 32'h0); exp_rd++;
        idle(); idle();
        chk("R8 flag stays set", {28'h0, err_flags}, 32'h1);
        clear_flags();
        chk("R8 clear empties flags", {28'h0, err_flags}, 32'h0);
        chk("R8 err_any after clear", {31'h0, err_any}, 32'h0);
        beat(1, 0, 3'b001, 16'h0050, 4'h3, 32'h0);
        beat(1, 0, 3'b001, 16'h0050, 4'h1, 32'h0);
        chk("R3 byte-enable change flagged", {28'h0, err_flags}, 32'h1);
        beat(1, 1, 3'b001, 16'h0050, 4'h1, 32'h0); exp_wr++;
        idle(); clear_flags();
    endtask

    task automatic t_wdata();
        beat(1, 0, 3'b001, 16'h0060, 4'h0, 32'h11111111);
        beat(1, 0, 3'b001, 16'h0060, 4'h0, 32'h22222222);
        chk("R4 write data change flagged", {28'h0, err_flags}, 32'h2);
        beat(1, 1, 3'b001, 16'h0060, 4'h0, 32'h22222222); exp_wr++;
        idle(); clear_flags();
        beat(1, 0, 3'b100, 16'h0061, 4'h0, 32'h33333333);
        beat(1, 0, 3'b100, 16'h0061, 4'h0, 32'h44444444);
        chk("R4 data change under read ignored", {28'h0, err_flags}, 32'h0);
        beat(1, 1, 3'b100, 16'h0061, 4'h0, 32'h44444444); exp_rd++;
        idle();
        chk("R1 R2 counts after data tests", {rd_count, wr_count}, {exp_rd[15:0], exp_wr[15:0]});
    endtask

    task automatic t_req_fall();
        beat(1, 0, 3'b100, 16'h0070, 4'h0, 32'h0);
        beat(0, 0, 3'b100, 16'h0070, 4'h0, 32'h0);
        chk("R5 early request fall", {28'h0, err_flags}, 32'h4);
        idle(); clear_flags();
    endtask

    task automatic t_ack_fall();
        beat(0, 1, 3'b000, 16'h0, 4'h0, 32'h0);
        chk("R6 early ack high is legal", {28'h0, err_flags}, 32'h0);
        beat(0, 0, 3'b000, 16'h0, 4'h0, 32'h0);
        chk("R6 early acknowledge fall", {28'h0, err_flags}, 32'h8);
        idle(); idle();
        chk("R8 ack flag sticky", {28'h0, err_flags}, 32'h8);
        // New request-fall violation lands in the clear cycle.
        beat(1, 0, 3'b100, 16'h0080, 4'h0, 32'h0);
        err_clr = 1'b1;
        beat(0, 0, 3'b100, 16'h0080, 4'h0, 32'h0);
        err_clr = 1'b0;
        chk("R8 set wins over clear", {28'h0, err_flags}, 32'h4);
        idle(); clear_flags();
    endtask

    task automatic t_warn();
        beat(1, 1, 3'b000, 16'h0090, 4'hF, 32'h0); exp_wr++;
        chk("R7 empty byte enables warn", {31'h0, warn_no_bytes}, 32'h1);
        chk("R7 no error from warning", {31'h0, err_any}, 32'h0);
        chk("R2 empty write still counted", {16'h0, wr_count}, exp_wr);
        idle(); idle();
        chk("R8 warning sticky", {31'h0, warn_no_bytes}, 32'h1);
        clear_flags();
        chk("R8 warning cleared", {31'h0, warn_no_bytes}, 32'h0);
        beat(1, 1, 3'b100, 16'h0091, 4'h7, 32'h0); exp_rd++;
        chk("R7 one active byte no warning", {31'h0, warn_no_bytes}, 32'h0);
        idle();
    endtask

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end

    initial begin : main
        repeat (3) @(posedge clk);
        #2;
        t_reset();
        rst_n = 1'b1;
        idle();
        t_reads();
        t_writes();
        t_hold_ctrl();
        t_wdata();
        t_req_fall();
        t_ack_fall();
        t_warn();
        chk("R1 final read count", {16'h0, rd_count}, exp_rd);
        chk("R2 final write count", {16'h0, wr_count}, exp_wr);
        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end
endmodule